// File: doc/BRIEF.md
# Floating-Point Set-on-Compare Unit

This unit evaluates a relation between two IEEE-754 operands and records the outcome as a single status bit. It accepts 32-bit single-precision or 64-bit double-precision values. A per-operation select chooses the precision. A double-precision operand is expected to arrive already joined from an even/odd pair of floating-point registers.

A 3-bit predicate code picks one of six relations: less than, greater than, equal, less-or-equal, greater-or-equal and not-equal. When the valid strobe is high at a rising clock edge, the status bit is loaded with 1 if the relation holds and with 0 if it does not. At all other edges the bit keeps its value. Signed zeros compare as equal. Any comparison that involves a NaN is unordered.

Top module: `fpsr_compare_unit`

## Requirements
- R1: With `dbl_sel`=0 the operands are single precision and occupy bits [31:0] of `opnd_a`/`opnd_b`. Bit 31 is the sign, bits [30:23] are the exponent and bits [22:0] are the fraction. Bits [63:32] have no effect on the result.
- R2: With `dbl_sel`=1 the operands are double precision and use all 64 bits. Bit 63 is the sign, bits [62:52] are the exponent and bits [51:0] are the fraction.
- R3: The predicate codes are 0=LT, 1=GT, 2=EQ, 3=LE, 4=GE and 5=NE, each testing A against B. The status bit is loaded with 1 when the relation holds and with 0 when it does not.
- R4: Positive zero and negative zero compare as equal to each other.
- R5: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If either operand is a NaN, codes 0 to 4 give 0 and code 5 gives 1.
- R6: Ordering follows sign and magnitude. A negative value is below a positive one, and between two negative values the larger magnitude is the smaller value. Infinities order as the extreme values.
- R7: Codes 6 and 7 leave the status bit unchanged even when `op_valid` is high.
- R8: The status bit changes only at a rising edge where `op_valid` is high, and is visible right after that edge. With `op_valid` low it holds its value whatever the other inputs do.
- R9: While `rst_n` is low, the status bit is 0. The reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Compare strobe |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision |
| pred_code | input | 3 | Relation select |
| opnd_a | input | 64 | Left operand |
| opnd_b | input | 64 | Right operand |
| fpsr_flag | output | 1 | Registered compare status bit |

## Verification
The checker watches the following on every cycle:
- the status bit holds when there is no strobe or when the code is reserved;
- the status bit is cleared on an unordered compare, except under not-equal;
- the less-than and equal outputs are never both high, and both are low when the compare is unordered;
- a pair of zeros is always seen as equal;
- a negative operand against a positive one always orders as less.

The exact relation result for each code, precision isolation from the unused upper bits, and ordering between negative magnitudes and infinities can only be shown by the bench's scenarios. The bench checks those against its own ordering-key model of IEEE values.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int DP_W   = 64;
  localparam int SP_W   = 32;
  localparam int DP_EXP = 11;
  localparam int SP_EXP = 8;
  localparam int MAG_W  = DP_W - 1;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PR_LT = 3'd0,
    PR_GT = 3'd1,
    PR_EQ = 3'd2,
    PR_LE = 3'd3,
    PR_GE = 3'd4,
    PR_NE = 3'd5
  } pred_e;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             zero;
  } opnd_view_t;

  // Relation result for a legal code; unordered operands fail all but NE.
  function automatic logic pred_eval(logic [CODE_W-1:0] code, logic lt,
                                     logic eq, logic unord);
    logic gt;
    logic r;
    gt = !lt && !eq && !unord;
    case (code)
      PR_LT:   r = lt;
      PR_GT:   r = gt;
      PR_EQ:   r = eq;
      PR_LE:   r = lt || eq;
      PR_GE:   r = gt || eq;
      PR_NE:   r = !eq;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic code_is_legal(logic [CODE_W-1:0] code);
    return code <= PR_NE;
  endfunction
endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [WORD_W-1:0] raw_i,
  output opnd_view_t        view_o
);
  localparam int FRAC_W = WORD_W - EXP_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = raw_i[WORD_W-2 -: EXP_W];
  assign frac_f = raw_i[FRAC_W-1:0];

  always_comb begin
    view_o.sign = raw_i[WORD_W-1];
    view_o.mag  = MAG_W'(raw_i[WORD_W-2:0]);
    view_o.nan  = (&exp_f) && (|frac_f);
    view_o.zero = ~|raw_i[WORD_W-2:0];
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  opnd_view_t a_i,
  input  opnd_view_t b_i,
  output logic       lt_o,
  output logic       eq_o,
  output logic       unord_o
);
  logic both_zero;
  logic mag_lt;
  logic mag_gt;

  assign both_zero = a_i.zero && b_i.zero;
  assign mag_lt    = a_i.mag < b_i.mag;
  assign mag_gt    = a_i.mag > b_i.mag;
  assign unord_o   = a_i.nan || b_i.nan;

  always_comb begin
    lt_o = 1'b0;
    eq_o = 1'b0;
    if (!unord_o) begin
      if (both_zero) begin
        eq_o = 1'b1;
      end else if (a_i.sign != b_i.sign) begin
        lt_o = a_i.sign;
      end else begin
        eq_o = (a_i.mag == b_i.mag);
        lt_o = a_i.sign ? mag_gt : mag_lt;
      end
    end
  end
endmodule

// File: rtl/fpsr_compare_unit.sv
module fpsr_compare_unit
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              dbl_sel,
  input  logic [CODE_W-1:0] pred_code,
  input  logic [DP_W-1:0]   opnd_a,
  input  logic [DP_W-1:0]   opnd_b,
  output logic              fpsr_flag
);
  opnd_view_t views [2];
  logic       cmp_lt;
  logic       cmp_eq;
  logic       cmp_unord;
  logic       pred_hit;
  logic       code_legal;
  logic       flag_load;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic [DP_W-1:0] word;
    opnd_view_t      sp_view;
    opnd_view_t      dp_view;

    assign word = (g == 0) ? opnd_a : opnd_b;

    fpcmp_unpack #(.WORD_W(SP_W), .EXP_W(SP_EXP)) u_sp (
      .raw_i (word[SP_W-1:0]),
      .view_o(sp_view)
    );
    fpcmp_unpack #(.WORD_W(DP_W), .EXP_W(DP_EXP)) u_dp (
      .raw_i (word),
      .view_o(dp_view)
    );

    assign views[g] = dbl_sel ? dp_view : sp_view;
  end

  fpcmp_order u_order (
    .a_i    (views[0]),
    .b_i    (views[1]),
    .lt_o   (cmp_lt),
    .eq_o   (cmp_eq),
    .unord_o(cmp_unord)
  );

  assign pred_hit   = pred_eval(pred_code, cmp_lt, cmp_eq, cmp_unord);
  assign code_legal = code_is_legal(pred_code);
  assign flag_load  = op_valid && code_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpsr_flag <= 1'b0;
    end else if (flag_load) begin
      fpsr_flag <= pred_hit;
    end
  end
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker
  import fpcmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              dbl_sel,
  input logic [CODE_W-1:0] pred_code,
  input logic [DP_W-1:0]   opnd_a,
  input logic [DP_W-1:0]   opnd_b,
  input logic              fpsr_flag,
  input logic              cmp_lt,
  input logic              cmp_eq,
  input logic              cmp_unord
);
  logic a_zero, b_zero, a_neg, b_neg;

  assign a_zero = dbl_sel ? (opnd_a[62:0] == '0) : (opnd_a[30:0] == '0);
  assign b_zero = dbl_sel ? (opnd_b[62:0] == '0) : (opnd_b[30:0] == '0);
  assign a_neg  = dbl_sel ? opnd_a[63] : opnd_a[31];
  assign b_neg  = dbl_sel ? opnd_b[63] : opnd_b[31];

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(fpsr_flag));

  a_r7_reserved_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pred_code > 3'd5) |=> $stable(fpsr_flag));

  a_r5_unordered_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cmp_unord && pred_code < 3'd5) |=> !fpsr_flag);

  a_r5_unordered_ne_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cmp_unord && pred_code == 3'd5) |=> fpsr_flag);

  a_r3_lt_eq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_lt && cmp_eq));

  a_r5_unordered_no_relation: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_unord |-> (!cmp_lt && !cmp_eq));

  a_r4_zeros_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (a_zero && b_zero) |-> (cmp_eq && !cmp_lt));

  a_r6_negative_below_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_unord && !(a_zero && b_zero) && a_neg && !b_neg) |-> cmp_lt);
endmodule

bind fpsr_compare_unit fpcmp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .dbl_sel  (dbl_sel),
  .pred_code(pred_code),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .fpsr_flag(fpsr_flag),
  .cmp_lt   (cmp_lt),
  .cmp_eq   (cmp_eq),
  .cmp_unord(cmp_unord)
);

// File: tb/sim_fpsr_compare_unit.sv
module sim_fpsr_compare_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        dbl_sel = 1'b0;
  logic [2:0]  pred_code = 3'd0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        fpsr_flag;

  int    checks = 0;
  int    errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    model_flag = 1'b0;

  always #10 clk = ~clk;

  fpsr_compare_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dbl_sel(dbl_sel),
    .pred_code(pred_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .fpsr_flag(fpsr_flag)
  );

  // Independent model: map each value to an unsigned key that orders like the reals.
  function automatic logic [63:0] left_align(bit dbl, logic [63:0] x);
    return dbl ? x : {x[31:0], 32'h0};
  endfunction

  function automatic bit is_nan(bit dbl, logic [63:0] x);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [63:0] order_key(bit dbl, logic [63:0] x);
    logic [63:0] v;
    v = left_align(dbl, x);
    if (v[62:0] == 0) v = 64'h0;
    return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
  endfunction

  function automatic bit model(bit dbl, int code, logic [63:0] a, logic [63:0] b);
    logic [63:0] ka, kb;
    if (is_nan(dbl, a) || is_nan(dbl, b)) return code == 5;
    ka = order_key(dbl, a);
    kb = order_key(dbl, b);
    case (code)
      0: return ka < kb;
      1: return ka > kb;
      2: return ka == kb;
      3: return ka <= kb;
      4: return ka >= kb;
      default: return ka != kb;
    endcase
  endfunction

  task automatic issue(bit dbl, int code, logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk);
    dbl_sel   = dbl;
    pred_code = 3'(code);
    opnd_a    = a;
    opnd_b    = b;
    op_valid  = 1'b1;
    if (code <= 5) model_flag = model(dbl, code, a, b);
    exp_q.push_back(model_flag);
    tag_q.push_back(tag);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic all_codes(bit dbl, logic [63:0] a, logic [63:0] b, string tag);
    for (int c = 0; c < 6; c++) issue(dbl, c, a, b, tag);
  endtask

  task automatic check_now(bit exp, string tag);
    checks++;
    if (fpsr_flag !== exp) begin
      errors++;
      $display("FAIL %s: flag=%0b expected=%0b", tag, fpsr_flag, exp);
    end
  endtask

  // Monitor: after each strobed edge, compare against the queued expectation.
  always @(posedge clk) begin
    if (rst_n && op_valid) begin
      #2;
      if (exp_q.size() != 0) check_now(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(1'b0, "R9 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check_now(1'b0, "R9 after release");

    // R3/R6 single precision: 1.0 vs 2.0, 2.0 vs 1.0, equal values
    all_codes(1'b0, 64'h3F800000, 64'h40000000, "R3 sp 1<2");
    all_codes(1'b0, 64'h40000000, 64'h3F800000, "R3 sp 2>1");
    all_codes(1'b0, 64'h40000000, 64'h40000000, "R3 sp equal");
    // R6 negatives and mixed signs
    all_codes(1'b0, 64'hC0000000, 64'hBF800000, "R6 sp -2<-1");
    all_codes(1'b0, 64'hBF800000, 64'h3F800000, "R6 sp -1<1");
    all_codes(1'b0, 64'h7F800000, 64'h7F7FFFFF, "R6 sp inf>max");
    all_codes(1'b0, 64'hFF800000, 64'hC0000000, "R6 sp -inf<-2");
    // R4 signed zeros
    all_codes(1'b0, 64'h80000000, 64'h00000000, "R4 sp -0==+0");
    all_codes(1'b1, 64'h0, 64'h8000_0000_0000_0000, "R4 dp +0==-0");
    // R5 NaN
    all_codes(1'b0, 64'h7FC00000, 64'h3F800000, "R5 sp nan a");
    all_codes(1'b1, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, "R5 dp nan b");
    // R1 upper bits ignored in single precision
    all_codes(1'b0, 64'hFFFF_FFFF_3F80_0000, 64'h7FF8_0000_4000_0000, "R1 sp upper ignored");
    all_codes(1'b0, 64'h1234_5678_4000_0000, 64'h0000_0000_4000_0000, "R1 sp upper eq");
    // R2 double precision
    all_codes(1'b1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, "R2 dp 1<2");
    all_codes(1'b1, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R2 dp -2<-1");
    all_codes(1'b1, 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, "R2 dp low frac bit");
    all_codes(1'b1, 64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R2 dp inf>1");

    // R7 reserved codes keep the flag: set it to 1, then try codes 6/7 that would clear it
    issue(1'b0, 2, 64'h3F800000, 64'h3F800000, "R7 setup");
    issue(1'b0, 6, 64'h3F800000, 64'h40000000, "R7 code6 hold 1");
    issue(1'b0, 7, 64'h7FC00000, 64'h3F800000, "R7 code7 hold 1");
    issue(1'b0, 1, 64'h3F800000, 64'h40000000, "R7 setup 0");
    issue(1'b0, 7, 64'h40000000, 64'h3F800000, "R7 code7 hold 0");

    // R8 no strobe: inputs that would set the flag leave it alone
    @(negedge clk);
    dbl_sel = 1'b0; pred_code = 3'd5; opnd_a = 64'h1; opnd_b = 64'h2;
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_now(model_flag, "R8 idle hold");
    issue(1'b0, 5, 64'h1, 64'h2, "R8 strobe loads");
    @(negedge clk);
    pred_code = 3'd2;
    repeat (2) @(negedge clk);
    check_now(model_flag, "R8 idle hold after load");

    // R9 asynchronous reset clears the flag mid-cycle
    #3 rst_n = 1'b0;
    #2 check_now(1'b0, "R9 async reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule